// File: doc/BRIEF.md
# Layer pixel alpha blender

The block composites one overlay pixel onto a background pixel and accepts one pixel per clock on a valid/ready stream. A control word chooses how the overlay combines with the background: the overlay covers the background fully, a single constant alpha applies to the whole layer, or each pixel carries its own alpha. Per-pixel alpha can be blended as coverage (straight) alpha or as premultiplied alpha. When the layer is switched off, the background passes through unchanged.

Incoming pixels declare the width of their alpha: none, 1 bit, 2 bits or a full 8 bits. Codes of 1 or 2 bits are widened to 8 bits through a lookup register that holds four 8-bit opacity values. Software writes the control word and the lookup register through a single write strobe with a register select. The result leaves the block two cycles after a pixel is accepted. A low ready from downstream freezes the whole pipeline.

Top module: `layer_alpha_blend`

## Requirements
- R1: After reset the output stream is empty (out_valid_o low), the layer is disabled so a pixel passes the background through, and the lookup register holds 0xffaa5500.
- R2: When control bit 0 (layer enable) is clear, the output equals the background pixel in every composition mode.
- R3: With the layer enabled, the 2-bit composition field at control bits 13:12 selects the mode: 3 means per-pixel alpha, 2 means constant plane alpha, and 0 or 1 mean opaque, where the output equals the overlay pixel.
- R4: In plane alpha mode the alpha is control bits 23:16, the coverage formula of R5 applies, and neither the pixel alpha nor its width has any effect.
- R5: Coverage blending computes, per channel, out = (a*src + (255-a)*dst + 127) / 255.
- R6: Control bit 14 selects premultiplied blending in per-pixel mode only: out = src + ((255-a)*dst + 127) / 255, saturated to the largest channel value. In plane alpha mode the bit has no effect.
- R7: Alpha width code 0 means the pixel has no alpha, and the alpha is taken as 0xFF.
- R8: Alpha width code 1 takes alpha bit 0: set selects lookup byte 3 (bits 31:24), clear selects lookup byte 0 (bits 7:0).
- R9: Alpha width code 2 takes alpha bits 1:0 as an index n and selects lookup byte n (bits 8n+7:8n). The lookup register is written when cfg_we_i is high with cfg_sel_i high. A write with cfg_sel_i low loads the control word.
- R10: Alpha width code 3 uses the 8-bit pixel alpha directly.
- R11: A pixel accepted at a clock edge appears on the output after the second edge, and back-to-back pixels leave one per clock.
- R12: While out_ready_i is low, in_ready_o is low, and a valid output holds its value and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 selects the control word, 1 selects the lookup register |
| cfg_wdata_i | input | 32 | Register write data |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high together with valid |
| alpha_fmt_i | input | 2 | Alpha width of the pixel: 0 none, 1 one bit, 2 two bits, 3 eight bits |
| src_alpha_i | input | 8 | Overlay pixel alpha |
| src_rgb_i | input | NUM_CH*CH_W | Overlay pixel, channel 0 in the low bits |
| dst_rgb_i | input | NUM_CH*CH_W | Background pixel |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready; low stalls the pipeline |
| out_rgb_o | output | NUM_CH*CH_W | Blended pixel |

## Verification
The bench builds the block with its default parameters: three 8-bit channels and the lookup register resetting to 0xffaa5500. At these values the background term stays exactly at its endpoints for alpha 0x00 and 0xFF. A large overlay channel with a bright background pushes the premultiplied sum past 255, so saturation is exercised. The default lookup ramp makes each 1- and 2-bit code give a distinct alpha, and a later rewrite of the register shows that codes follow the programmed bytes rather than fixed values.

// File: rtl/lab_pkg.sv
package lab_pkg;
  typedef enum logic [1:0] {
    MD_DST = 2'd0,
    MD_COV = 2'd1,
    MD_PRE = 2'd2
  } blend_mode_e;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned COMP_LO     = 12;
  localparam int unsigned PMUL_BIT    = 14;
  localparam int unsigned PALPHA_LO   = 16;
  localparam int unsigned ALPHA_W     = 8;

  localparam logic [1:0] COMP_PIXEL = 2'd3;
  localparam logic [1:0] COMP_PLANE = 2'd2;
endpackage

// File: rtl/lab_cfg_regs.sv
module lab_cfg_regs
  import lab_pkg::*;
#(
  parameter logic [31:0] LUT_INIT = 32'hffaa5500
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [31:0]        wdata_i,
  output logic               en_o,
  output logic [1:0]         comp_o,
  output logic               pmul_o,
  output logic [ALPHA_W-1:0] plane_alpha_o,
  output logic [31:0]        lut_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o          <= 1'b0;
      comp_o        <= '0;
      pmul_o        <= 1'b0;
      plane_alpha_o <= '0;
      lut_o         <= LUT_INIT;
    end else if (we_i) begin
      if (sel_i) begin
        lut_o <= wdata_i;
      end else begin
        en_o          <= wdata_i[CTRL_EN_BIT];
        comp_o        <= wdata_i[COMP_LO+:2];
        pmul_o        <= wdata_i[PMUL_BIT];
        plane_alpha_o <= wdata_i[PALPHA_LO+:ALPHA_W];
      end
    end
  end

  // R9
  lut_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i) |=> (lut_o == $past(wdata_i)));
endmodule

// File: rtl/lab_alpha_sel.sv
module lab_alpha_sel
  import lab_pkg::*;
(
  input  logic               en_i,
  input  logic [1:0]         comp_i,
  input  logic               pmul_i,
  input  logic [ALPHA_W-1:0] plane_alpha_i,
  input  logic [31:0]        lut_i,
  input  logic [1:0]         fmt_i,
  input  logic [ALPHA_W-1:0] pix_alpha_i,
  output logic [ALPHA_W-1:0] alpha_o,
  output blend_mode_e        mode_o
);
  logic [ALPHA_W-1:0] pix_exp;

  always_comb begin
    unique case (fmt_i)
      2'd0:    pix_exp = '1;
      2'd1:    pix_exp = pix_alpha_i[0] ? lut_i[31:24] : lut_i[7:0];
      2'd2:    pix_exp = lut_i[8*pix_alpha_i[1:0]+:8];
      default: pix_exp = pix_alpha_i;
    endcase
  end

  always_comb begin
    alpha_o = '1;
    mode_o  = MD_COV;
    if (!en_i) begin
      mode_o = MD_DST;
    end else if (comp_i == COMP_PIXEL) begin
      alpha_o = pix_exp;
      mode_o  = pmul_i ? MD_PRE : MD_COV;
    end else if (comp_i == COMP_PLANE) begin
      alpha_o = plane_alpha_i;
    end
  end
endmodule

// File: rtl/lab_blend_chan.sv
module lab_blend_chan
  import lab_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  blend_mode_e        mode_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  input  logic [CH_W-1:0]    src_i,
  input  logic [CH_W-1:0]    dst_i,
  output logic [CH_W-1:0]    pix_o
);
  localparam int unsigned PW = CH_W + 2 * ALPHA_W;
  localparam logic [PW-1:0] MAXV = PW'((1 << CH_W) - 1);

  logic [PW-1:0] a_w, ia_w, s_w, d_w, cov_w, bg_w, pre_w;

  always_comb begin
    a_w   = PW'(alpha_i);
    ia_w  = PW'(8'd255 - alpha_i);
    s_w   = PW'(src_i);
    d_w   = PW'(dst_i);
    cov_w = (a_w * s_w + ia_w * d_w + PW'(127)) / PW'(255);
    bg_w  = (ia_w * d_w + PW'(127)) / PW'(255);
    pre_w = s_w + bg_w;
    if (pre_w > MAXV) pre_w = MAXV;
    unique case (mode_i)
      MD_DST:  pix_o = dst_i;
      MD_PRE:  pix_o = pre_w[CH_W-1:0];
      default: pix_o = cov_w[CH_W-1:0];
    endcase
  end
endmodule

// File: rtl/layer_alpha_blend.sv
module layer_alpha_blend
  import lab_pkg::*;
#(
  parameter int unsigned CH_W     = 8,
  parameter int unsigned NUM_CH   = 3,
  parameter logic [31:0] LUT_INIT = 32'hffaa5500
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic                   cfg_sel_i,
  input  logic [31:0]            cfg_wdata_i,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [1:0]             alpha_fmt_i,
  input  logic [7:0]             src_alpha_i,
  input  logic [NUM_CH*CH_W-1:0] src_rgb_i,
  input  logic [NUM_CH*CH_W-1:0] dst_rgb_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [NUM_CH*CH_W-1:0] out_rgb_o
);
  localparam int unsigned PIX_W = NUM_CH * CH_W;

  logic               en_q, pmul_q;
  logic [1:0]         comp_q;
  logic [ALPHA_W-1:0] palpha_q;
  logic [31:0]        lut_q;

  lab_cfg_regs #(.LUT_INIT(LUT_INIT)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (cfg_we_i),
    .sel_i         (cfg_sel_i),
    .wdata_i       (cfg_wdata_i),
    .en_o          (en_q),
    .comp_o        (comp_q),
    .pmul_o        (pmul_q),
    .plane_alpha_o (palpha_q),
    .lut_o         (lut_q)
  );

  logic [ALPHA_W-1:0] sel_alpha;
  blend_mode_e        sel_mode;

  lab_alpha_sel u_sel (
    .en_i          (en_q),
    .comp_i        (comp_q),
    .pmul_i        (pmul_q),
    .plane_alpha_i (palpha_q),
    .lut_i         (lut_q),
    .fmt_i         (alpha_fmt_i),
    .pix_alpha_i   (src_alpha_i),
    .alpha_o       (sel_alpha),
    .mode_o        (sel_mode)
  );

  // whole pipeline advances only when downstream is ready
  logic advance;
  assign advance    = out_ready_i;
  assign in_ready_o = advance;

  logic               s1_valid;
  blend_mode_e        s1_mode;
  logic [ALPHA_W-1:0] s1_alpha;
  logic [PIX_W-1:0]   s1_src, s1_dst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_mode  <= MD_DST;
      s1_alpha <= '0;
      s1_src   <= '0;
      s1_dst   <= '0;
    end else if (advance) begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_mode  <= sel_mode;
        s1_alpha <= sel_alpha;
        s1_src   <= src_rgb_i;
        s1_dst   <= dst_rgb_i;
      end
    end
  end

  logic [PIX_W-1:0] blend_rgb;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lab_blend_chan #(.CH_W(CH_W)) u_chan (
      .mode_i  (s1_mode),
      .alpha_i (s1_alpha),
      .src_i   (s1_src[c*CH_W+:CH_W]),
      .dst_i   (s1_dst[c*CH_W+:CH_W]),
      .pix_o   (blend_rgb[c*CH_W+:CH_W])
    );

    // R6
    premul_nowrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (advance && s1_valid && s1_mode == MD_PRE) |=>
        (out_rgb_o[c*CH_W+:CH_W] >= $past(s1_src[c*CH_W+:CH_W])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_rgb_o   <= '0;
    end else if (advance) begin
      out_valid_o <= s1_valid;
      if (s1_valid) out_rgb_o <= blend_rgb;
    end
  end

  // R12
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_rgb_o)));

  // R2
  disabled_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !en_q) |=> (s1_mode == MD_DST));

  // R4
  plane_alpha_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && en_q && comp_q == COMP_PLANE) |=>
      (s1_alpha == $past(palpha_q) && s1_mode == MD_COV));

  // R11
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && advance) |=> out_valid_o);
endmodule

// File: tb/layer_alpha_blend_bench.sv
module layer_alpha_blend_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0, in_ready;
  logic [1:0]  fmt = '0;
  logic [7:0]  sa = '0;
  logic [23:0] src = '0, dst = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [23:0] out_rgb;

  layer_alpha_blend u_layer_alpha_blend (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .alpha_fmt_i(fmt), .src_alpha_i(sa),
    .src_rgb_i(src), .dst_rgb_i(dst),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_rgb_o(out_rgb)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] lut_m = 32'hffaa5500;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [7:0] chan(input logic [1:0] md, input logic [7:0] a,
                                      input logic [7:0] s, input logic [7:0] d);
    int unsigned r;
    if (md == 0) return d;
    if (md == 2) begin
      r = s + ((255 - a) * d + 127) / 255;
      return (r > 255) ? 8'd255 : r[7:0];
    end
    r = (a * s + (255 - a) * d + 127) / 255;
    return r[7:0];
  endfunction

  function automatic logic [23:0] model(input logic [31:0] c, input logic [1:0] f,
                                        input logic [7:0] al, input logic [23:0] s,
                                        input logic [23:0] d, input logic [31:0] lut);
    logic [7:0] a;
    logic [1:0] md;
    logic [23:0] o;
    case (f)
      2'd0: a = 8'hff;
      2'd1: a = al[0] ? lut[31:24] : lut[7:0];
      2'd2: a = lut[8*al[1:0]+:8];
      default: a = al;
    endcase
    md = 1;
    if (!c[0]) md = 0;
    else if (c[13:12] == 2'd3) md = c[14] ? 2 : 1;
    else if (c[13:12] == 2'd2) a = c[23:16];
    else a = 8'hff;
    for (int i = 0; i < 3; i++) o[8*i+:8] = chan(md, a, s[8*i+:8], d[8*i+:8]);
    return o;
  endfunction

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) lut_m = d;
  endtask

  // drive one pixel and sample it after the second edge
  task automatic one_pixel(input string req, input logic [31:0] c, input logic [1:0] f,
                           input logic [7:0] al, input logic [23:0] s, input logic [23:0] d);
    @(negedge clk);
    in_valid = 1'b1; fmt = f; sa = al; src = s; dst = d;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " rgb"}, {8'd0, out_rgb}, {8'd0, model(c, f, al, s, d, lut_m)});
  endtask

  typedef struct packed {
    logic [31:0] ctrl;
    logic [1:0]  fmt;
    logic [7:0]  sa;
    logic [23:0] src;
    logic [23:0] dst;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_3000, 2'd3, 8'h80, 24'h112233, 24'h445566}, // R2 disabled, pixel mode
    '{32'h0000_2000, 2'd0, 8'h00, 24'hffffff, 24'h0a0b0c}, // R2 disabled, plane mode
    '{32'h0000_0001, 2'd3, 8'h00, 24'h123456, 24'h654321}, // R3 opaque comp 0
    '{32'h0000_1001, 2'd2, 8'h00, 24'hfedcba, 24'h010203}, // R3 opaque comp 1
    '{32'h0080_2001, 2'd3, 8'h10, 24'hc08040, 24'h204060}, // R4 plane alpha, pixel alpha ignored
    '{32'h0080_6001, 2'd1, 8'h00, 24'hc08040, 24'hf0f0f0}, // R6 premult bit ignored in plane mode
    '{32'h0000_3001, 2'd3, 8'h40, 24'hff8000, 24'h00ff80}, // R5 R10 coverage
    '{32'h0000_7001, 2'd3, 8'h40, 24'hf0a010, 24'hffffff}, // R6 premult saturates
    '{32'h0000_7001, 2'd3, 8'hc0, 24'h302010, 24'h808080}, // R6 premult no saturation
    '{32'h0000_3001, 2'd0, 8'h00, 24'h13579b, 24'h2468ac}, // R7 no alpha
    '{32'h0000_3001, 2'd1, 8'h01, 24'h13579b, 24'h2468ac}, // R8 bit set
    '{32'h0000_3001, 2'd1, 8'hfe, 24'h13579b, 24'h2468ac}, // R8 bit clear
    '{32'h0000_3001, 2'd2, 8'h01, 24'h90c030, 24'h306090}, // R9 code 1
    '{32'h0000_3001, 2'd2, 8'hfe, 24'h90c030, 24'h306090}  // R9 code 2
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    // R1 layer disabled by default: background passes
    one_pixel("R1 disabled default", 32'h0, 2'd3, 8'hff, 24'haabbcc, 24'h102030);
    // R1 R9 lookup default: 2-bit code 3 gives 0xff -> overlay
    cfg_write(1'b0, 32'h0000_3001);
    one_pixel("R1 lut default", 32'h0000_3001, 2'd2, 8'h03, 24'haabbcc, 24'h102030);

    foreach (VEC[i]) begin
      cfg_write(1'b0, VEC[i].ctrl);
      one_pixel($sformatf("vec%0d", i), VEC[i].ctrl, VEC[i].fmt, VEC[i].sa,
                VEC[i].src, VEC[i].dst);
    end

    // R9 programmed lookup bytes
    cfg_write(1'b1, 32'h1020_3040);
    cfg_write(1'b0, 32'h0000_3001);
    one_pixel("R9 lut code 3", 32'h0000_3001, 2'd2, 8'h03, 24'hf0f0f0, 24'h0f0f0f);
    one_pixel("R9 lut code 0", 32'h0000_3001, 2'd2, 8'h00, 24'hf0f0f0, 24'h0f0f0f);
    one_pixel("R8 lut byte 3", 32'h0000_3001, 2'd1, 8'h01, 24'hf0f0f0, 24'h0f0f0f);
    one_pixel("R8 lut byte 0", 32'h0000_3001, 2'd1, 8'h00, 24'hf0f0f0, 24'h0f0f0f);

    // R11 back-to-back throughput
    cfg_write(1'b0, 32'h0000_0001);
    @(negedge clk);
    in_valid = 1'b1; fmt = 0; src = 24'h000001; dst = 0;
    @(negedge clk);
    src = 24'h000002;
    @(negedge clk);
    check("R11 first", {8'd0, out_rgb}, 32'h000001);
    check("R11 first valid", {31'd0, out_valid}, 32'd1);
    src = 24'h000003;
    @(negedge clk);
    check("R11 second", {8'd0, out_rgb}, 32'h000002);
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 third", {8'd0, out_rgb}, 32'h000003);
    @(negedge clk);
    check("R11 drained", {31'd0, out_valid}, 32'd0);

    // R12 stall
    in_valid = 1'b1; src = 24'h5a5a5a;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R12 pre-stall valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12 held valid", {31'd0, out_valid}, 32'd1);
      check("R12 held rgb", {8'd0, out_rgb}, 32'h5a5a5a);
      check("R12 in_ready low", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R12 released", {31'd0, out_valid}, 32'd0);

    summary();
    $finish;
  end
endmodule